// File: doc/BRIEF.md
# Graphics Command Packet Parser

This block sits between a 32-bit command word stream and a rendering back end. The top byte of the first word of each packet is its opcode. A length table gives the number of extra words that follow each opcode. The block gathers every word of a packet before it forwards any of them. It then sends the packet one word per cycle over a valid/ready output and marks the final word.

As words arrive, the block watches a few opcodes and copies fields from them into a 32-bit status word. For textured primitives, the texture-page bits come from a word inside the packet. The two image-memory transfer opcodes never reach the back end. Their position and size words go to a rectangle-transfer engine, together with a direction flag.

While that engine reports a transfer in progress, the block passes incoming words straight to the engine and does not parse them as commands.

Top module: `gpkt_parser`

## Requirements
- R1: After a synchronous reset the status output equals 0x14802000. `out_valid` and `xfer_start` are low and `in_ready` is high.
- R2: The opcode is bits 31:24 of a packet's first word, and the packet holds 1 + N words. N is:
  - 3 for 0x20-23, 6 for 0x24-27, 4 for 0x28-2B, 8 for 0x2C-2F;
  - 5 for 0x30-33, 8 for 0x34-37, 7 for 0x38-3B, 11 for 0x3C-3F;
  - 2 for 0x02, 0x40-43, 0x60-63, 0xA0 and 0xC0;
  - 3 for 0x48-4F, 0x50-53, 0x64-67 and 0x80;
  - 4 for 0x58-5F;
  - 1 for 0x68-6B, 0x70-73 and 0x78-7B;
  - 2 for 0x6C-6F, 0x74-77 and 0x7C-7F;
  - 0 for every other opcode.
- R3: A forwarded packet appears on `out_data` in arrival order. `out_valid` rises in the cycle after its last word is accepted, and `out_last` is high only with the final word.
- R4: While a packet is being sent, `in_ready` is low. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R5: When (opcode AND 0xF4) = 0x24, status bits 8:0 take bits 8:0 of packet word 4, where the first word is word 0. Status changes only when a word is accepted.
- R6: When (opcode AND 0xF4) = 0x34, status bits 8:0 take bits 8:0 of packet word 5.
- R7: Opcode 0xE1 loads status bits 10:0 from bits 10:0 of its own word.
- R8: Opcode 0xE6 loads status bits 12:11 from bits 1:0 of its own word.
- R9: Opcodes 0xA0 and 0xC0 are not forwarded. `xfer_start` pulses for one cycle, in the cycle after the third word is accepted. At that point `xfer_pos` holds word 1 and `xfer_size` holds word 2. `xfer_read` is 1 for 0xC0 and 0 for 0xA0.
- R10: While `xfer_busy` is high and no partial packet is held, each accepted input word appears on `xfer_wvalid`/`xfer_wdata` in the same cycle. It is not parsed, so it neither forwards a packet nor changes the status.
- R11: A reset discards a partially gathered packet, so the next word after reset is parsed as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Packet word offered to back end |
| out_data | output | 32 | Packet word |
| out_last | output | 1 | Final word of the packet |
| out_ready | input | 1 | Back end takes the word |
| status | output | 32 | Snooped status word |
| xfer_start | output | 1 | One-cycle transfer launch |
| xfer_read | output | 1 | 1 = read from image memory |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_busy | input | 1 | Transfer engine is moving data |
| xfer_wvalid | output | 1 | Diverted word valid |
| xfer_wdata | output | 32 | Diverted word |

## Verification
A wrong word counter or a wrong latched length shows up as soon as the first packet after the fault is sent. `out_last` moves by at least one word, and every later opcode is taken from the wrong word, so the output stream and the status diverge within a few cycles. A wrong opcode or index on the snoop path shows in `status` one cycle after the affected word is accepted. A bad diversion decision shows in the same cycle on `xfer_wvalid`. The bench compares all of these outputs against a queue-based model in every cycle, so each fault is reported at the first cycle it is visible.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;

   typedef enum logic {ST_GATHER, ST_EMIT} gather_st_t;

   localparam int          LONGEST_PKT = 12;
   localparam logic [7:0]  OP_DRAWMODE = 8'hE1;
   localparam logic [7:0]  OP_MASKSET  = 8'hE6;
   localparam logic [7:0]  OP_IMG_WR   = 8'hA0;
   localparam logic [7:0]  OP_IMG_RD   = 8'hC0;
   localparam logic [7:0]  TEX_MASK    = 8'hF4;
   localparam logic [7:0]  TEX_FLAT    = 8'h24;
   localparam logic [7:0]  TEX_SHADED  = 8'h34;

   // words following the opcode word
   function automatic logic [3:0] op_extra(input logic [7:0] op);
      logic [3:0] n;
      case (op) inside
         8'h02:           n = 4'd2;
         [8'h20:8'h23]:   n = 4'd3;
         [8'h24:8'h27]:   n = 4'd6;
         [8'h28:8'h2B]:   n = 4'd4;
         [8'h2C:8'h2F]:   n = 4'd8;
         [8'h30:8'h33]:   n = 4'd5;
         [8'h34:8'h37]:   n = 4'd8;
         [8'h38:8'h3B]:   n = 4'd7;
         [8'h3C:8'h3F]:   n = 4'd11;
         [8'h40:8'h43]:   n = 4'd2;
         [8'h48:8'h4F]:   n = 4'd3;
         [8'h50:8'h53]:   n = 4'd3;
         [8'h58:8'h5F]:   n = 4'd4;
         [8'h60:8'h63]:   n = 4'd2;
         [8'h64:8'h67]:   n = 4'd3;
         [8'h68:8'h6B]:   n = 4'd1;
         [8'h6C:8'h6F]:   n = 4'd2;
         [8'h70:8'h73]:   n = 4'd1;
         [8'h74:8'h77]:   n = 4'd2;
         [8'h78:8'h7B]:   n = 4'd1;
         [8'h7C:8'h7F]:   n = 4'd2;
         8'h80:           n = 4'd3;
         8'hA0, 8'hC0:    n = 4'd2;
         default:         n = 4'd0;
      endcase
      return n;
   endfunction

   function automatic logic is_img_op(input logic [7:0] op);
      return (op == OP_IMG_WR) || (op == OP_IMG_RD);
   endfunction

endpackage

// File: rtl/gpkt_gather.sv
module gpkt_gather
   import gpkt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 12,
   parameter int IW        = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              xfer_busy,
   output logic              divert,
   output logic              acc,
   output logic [IW-1:0]     idx,
   output logic [7:0]        cur_op,
   output logic              done,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   input  logic              out_ready
);
   gather_st_t        st;
   logic [IW-1:0]     cnt, need, rd;
   logic [IW-1:0]     cur_need;
   logic [7:0]        op_q;
   logic              first;
   logic [DATA_W-1:0] slot [MAX_WORDS];

   assign first    = (cnt == '0);
   assign cur_op   = first ? in_data[DATA_W-1 -: 8] : op_q;
   assign cur_need = first ? (IW'(op_extra(in_data[DATA_W-1 -: 8])) + IW'(1)) : need;
   assign in_ready = (st == ST_GATHER);
   assign divert   = xfer_busy & first;
   assign acc      = in_valid & in_ready & ~divert;
   assign done     = acc & ((cnt + IW'(1)) == cur_need);
   assign idx      = cnt;

   assign out_valid = (st == ST_EMIT);
   assign out_data  = slot[rd];
   assign out_last  = (st == ST_EMIT) && (rd == need - IW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_GATHER;
         cnt  <= '0;
         need <= '0;
         rd   <= '0;
         op_q <= '0;
      end else begin
         case (st)
            ST_GATHER: if (acc) begin
               if (first) begin
                  op_q <= in_data[DATA_W-1 -: 8];
                  need <= cur_need;
               end
               if (done) begin
                  cnt <= '0;
                  if (!is_img_op(cur_op)) begin
                     st <= ST_EMIT;
                     rd <= '0;
                  end
               end else begin
                  cnt <= cnt + IW'(1);
               end
            end
            ST_EMIT: if (out_ready) begin
               if (rd == need - IW'(1)) st <= ST_GATHER;
               else                     rd <= rd + IW'(1);
            end
            default: st <= ST_GATHER;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < MAX_WORDS; i++)
         if (acc && (cnt == IW'(i))) slot[i] <= in_data;
   end

endmodule

// File: rtl/gpkt_status_snoop.sv
module gpkt_status_snoop
   import gpkt_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          IW        = 4,
   parameter logic [31:0] STS_RESET = 32'h1480_2000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc,
   input  logic [IW-1:0]     idx,
   input  logic [7:0]        op,
   input  logic [DATA_W-1:0] word,
   output logic [31:0]       status
);
   logic tex_flat, tex_shaded;

   assign tex_flat   = ((op & TEX_MASK) == TEX_FLAT)   && (idx == IW'(4));
   assign tex_shaded = ((op & TEX_MASK) == TEX_SHADED) && (idx == IW'(5));

   always_ff @(posedge clk) begin
      if (rst) begin
         status <= STS_RESET;
      end else if (acc) begin
         if (idx == '0 && op == OP_DRAWMODE) status[10:0]  <= word[10:0];
         if (idx == '0 && op == OP_MASKSET)  status[12:11] <= word[1:0];
         if (tex_flat || tex_shaded)         status[8:0]   <= word[8:0];
      end
   end

endmodule

// File: rtl/gpkt_xfer_tap.sv
module gpkt_xfer_tap
   import gpkt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IW     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc,
   input  logic [IW-1:0]     idx,
   input  logic [7:0]        op,
   input  logic [DATA_W-1:0] word,
   input  logic              done,
   output logic              xfer_start,
   output logic              xfer_read,
   output logic [DATA_W-1:0] xfer_pos,
   output logic [DATA_W-1:0] xfer_size
);
   always_ff @(posedge clk) begin
      if (rst) begin
         xfer_start <= 1'b0;
         xfer_read  <= 1'b0;
         xfer_pos   <= '0;
         xfer_size  <= '0;
      end else begin
         xfer_start <= 1'b0;
         if (acc && is_img_op(op) && idx == IW'(1)) xfer_pos <= word;
         if (done && is_img_op(op)) begin
            xfer_size  <= word;
            xfer_start <= 1'b1;
            xfer_read  <= (op == OP_IMG_RD);
         end
      end
   end

endmodule

// File: rtl/gpkt_parser.sv
module gpkt_parser
   import gpkt_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          MAX_WORDS = LONGEST_PKT,
   parameter bit          SNOOP_EN  = 1'b1,
   parameter logic [31:0] STS_RESET = 32'h1480_2000
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [31:0] in_data,
   output logic        in_ready,
   output logic        out_valid,
   output logic [31:0] out_data,
   output logic        out_last,
   input  logic        out_ready,
   output logic [31:0] status,
   output logic        xfer_start,
   output logic        xfer_read,
   output logic [31:0] xfer_pos,
   output logic [31:0] xfer_size,
   input  logic        xfer_busy,
   output logic        xfer_wvalid,
   output logic [31:0] xfer_wdata
);
   localparam int IW = $clog2(MAX_WORDS + 1);

   if (DATA_W != 32) begin : g_bad_width
      $error("gpkt_parser: DATA_W must be 32");
   end
   if (MAX_WORDS < LONGEST_PKT) begin : g_bad_depth
      $error("gpkt_parser: MAX_WORDS too small for longest packet");
   end

   logic          divert, acc, done;
   logic [IW-1:0] idx;
   logic [7:0]    cur_op;

   gpkt_gather #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .IW(IW)) u_gather (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .xfer_busy(xfer_busy), .divert(divert),
      .acc(acc), .idx(idx), .cur_op(cur_op), .done(done),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_ready(out_ready)
   );

   if (SNOOP_EN) begin : g_snoop
      gpkt_status_snoop #(.DATA_W(DATA_W), .IW(IW), .STS_RESET(STS_RESET)) u_snoop (
         .clk(clk), .rst(rst), .acc(acc), .idx(idx), .op(cur_op),
         .word(in_data), .status(status)
      );
   end else begin : g_fixed
      assign status = STS_RESET;
   end

   gpkt_xfer_tap #(.DATA_W(DATA_W), .IW(IW)) u_tap (
      .clk(clk), .rst(rst), .acc(acc), .idx(idx), .op(cur_op),
      .word(in_data), .done(done), .xfer_start(xfer_start),
      .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size)
   );

   assign xfer_wvalid = in_valid & in_ready & divert;
   assign xfer_wdata  = in_data;

endmodule

// File: rtl/gpkt_parser_chk.sv
module gpkt_parser_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic [31:0] out_data,
   input logic        out_last,
   input logic        out_ready,
   input logic [31:0] status,
   input logic        xfer_start,
   input logic        xfer_busy,
   input logic        xfer_wvalid
);
   AST_EMIT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst) out_valid |-> !in_ready); // R4
   AST_EMIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R4
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) xfer_start |=> !xfer_start); // R9
   AST_DIVERT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      xfer_wvalid |-> xfer_busy && in_valid && !out_valid); // R10
   AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(status)); // R5
   AST_DIVERT_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
      xfer_wvalid |=> $stable(status)); // R10
endmodule

bind gpkt_parser gpkt_parser_chk u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
   .out_ready(out_ready), .status(status), .xfer_start(xfer_start),
   .xfer_busy(xfer_busy), .xfer_wvalid(xfer_wvalid)
);

// File: tb/gpkt_parser_test.sv
module gpkt_parser_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_ready = 1'b1;
   logic        xfer_busy = 1'b0;
   logic        in_ready, out_valid, out_last, xfer_start, xfer_read, xfer_wvalid;
   logic [31:0] out_data, status, xfer_pos, xfer_size, xfer_wdata;

   gpkt_parser uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .out_ready(out_ready), .status(status),
      .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
      .xfer_size(xfer_size), .xfer_busy(xfer_busy), .xfer_wvalid(xfer_wvalid),
      .xfer_wdata(xfer_wdata)
   );

   always #10 clk = ~clk;

   int vectors = 0, miscmp = 0, cyc = 0, diverted = 0, starts = 0;
   bit stall_mode = 1'b0, finished = 1'b0;

   // reference model state
   logic [31:0] pk[$];
   logic [31:0] emq[$];
   logic [31:0] m_sts = 32'h1480_2000;
   logic        m_start = 1'b0, m_read = 1'b0;
   logic [31:0] m_pos = '0, m_size = '0;
   int          m_idx;
   logic [7:0]  m_op;

   function automatic int ref_extra(input logic [7:0] op);
      logic [2:0] g;
      g = op[4:2];
      if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) return 2;
      if (op == 8'h80) return 3;
      if (op >= 8'h20 && op <= 8'h3F) begin
         case (g)
            3'd0: return 3;  3'd1: return 6;  3'd2: return 4;  3'd3: return 8;
            3'd4: return 5;  3'd5: return 8;  3'd6: return 7;  default: return 11;
         endcase
      end
      if (op >= 8'h40 && op <= 8'h5F) begin
         case (g)
            3'd0: return 2;  3'd1: return 0;  3'd2, 3'd3, 3'd4: return 3;
            3'd5: return 0;  default: return 4;
         endcase
      end
      if (op >= 8'h60 && op <= 8'h7F) begin
         if (op < 8'h68) return op[2] ? 3 : 2;
         return op[2] ? 2 : 1;
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      m_start = 1'b0;
      if (rst) begin
         pk.delete(); emq.delete(); m_sts = 32'h1480_2000;
      end else if (emq.size() != 0) begin
         if (out_ready) void'(emq.pop_front());
      end else if (in_valid && !(xfer_busy && pk.size() == 0)) begin
         pk.push_back(in_data);
         m_idx = pk.size() - 1;
         m_op  = pk[0][31:24];
         if (m_idx == 0 && m_op == 8'hE1) m_sts[10:0] = in_data[10:0];
         if (m_idx == 0 && m_op == 8'hE6) m_sts[12:11] = in_data[1:0];
         if ((m_op & 8'hF4) == 8'h24 && m_idx == 4) m_sts[8:0] = in_data[8:0];
         if ((m_op & 8'hF4) == 8'h34 && m_idx == 5) m_sts[8:0] = in_data[8:0];
         if (pk.size() == 1 + ref_extra(m_op)) begin
            if (m_op == 8'hA0 || m_op == 8'hC0) begin
               m_start = 1'b1; m_pos = pk[1]; m_size = pk[2]; m_read = (m_op == 8'hC0);
            end else begin
               emq = pk;
            end
            pk.delete();
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscmp++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // out_ready pattern
   always @(negedge clk) begin
      cyc++;
      out_ready <= stall_mode ? (cyc % 3 != 0) : 1'b1;
   end

   // per-cycle comparison, midway between negedge and posedge
   always @(negedge clk) begin
      logic e_wv;
      #5;
      e_wv = in_valid && xfer_busy && pk.size() == 0 && emq.size() == 0;
      chk(in_ready === (emq.size() == 0), "R4 in_ready", 32'(in_ready), 32'(emq.size() == 0));
      chk(out_valid === (emq.size() != 0), "R3 out_valid", 32'(out_valid), 32'(emq.size() != 0));
      if (emq.size() != 0) begin
         chk(out_data === emq[0], "R3 out_data", out_data, emq[0]);
         chk(out_last === (emq.size() == 1), "R2 out_last", 32'(out_last), 32'(emq.size() == 1));
      end
      chk(status === m_sts, "R5 R6 R7 R8 status", status, m_sts);
      chk(xfer_start === m_start, "R9 xfer_start", 32'(xfer_start), 32'(m_start));
      if (m_start) begin
         chk(xfer_pos === m_pos, "R9 xfer_pos", xfer_pos, m_pos);
         chk(xfer_size === m_size, "R9 xfer_size", xfer_size, m_size);
         chk(xfer_read === m_read, "R9 xfer_read", 32'(xfer_read), 32'(m_read));
      end
      chk(xfer_wvalid === e_wv, "R10 xfer_wvalid", 32'(xfer_wvalid), 32'(e_wv));
      if (e_wv) chk(xfer_wdata === in_data, "R10 xfer_wdata", xfer_wdata, in_data);
      if (xfer_wvalid) diverted++;
      if (xfer_start) starts++;
   end

   task automatic push(input logic [31:0] w);
      bit r;
      in_valid = 1'b1;
      in_data  = w;
      forever begin
         r = in_ready;
         @(negedge clk);
         if (r) break;
      end
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [7:0] op, input int extra, input int sp_idx, input logic [31:0] sp_val);
      for (int i = 0; i <= extra; i++) begin
         if (i == 0) push({op, (sp_idx == 0) ? sp_val[23:0] : 24'h13_5790});
         else        push((i == sp_idx) ? sp_val : (32'h0101_0101 * i) ^ 32'hC3C3_0000);
      end
   endtask

   task automatic settle();
      repeat (20) @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(status === 32'h1480_2000 && !out_valid && in_ready && !xfer_start, "R1 reset state",
          status, 32'h1480_2000);

      send_pkt(8'hE1, 0, 0, 32'h0000_05A5); settle();
      chk(status === 32'h1480_25A5, "R7 draw-mode load", status, 32'h1480_25A5);
      send_pkt(8'hE6, 0, 0, 32'h0000_0003); settle();
      chk(status === 32'h1480_3DA5, "R8 mask bits", status, 32'h1480_3DA5);

      stall_mode = 1'b1;
      send_pkt(8'h20, 3, 9, 0);
      send_pkt(8'h24, 6, 4, 32'h0000_01FF); settle();
      chk(status === 32'h1480_3DFF, "R5 flat textured page", status, 32'h1480_3DFF);
      send_pkt(8'h3C, 11, 5, 32'hFFFF_FE42); settle();
      chk(status === 32'h1480_3C42, "R6 shaded textured page", status, 32'h1480_3C42);
      send_pkt(8'h02, 2, 9, 0);
      send_pkt(8'h80, 3, 9, 0);
      stall_mode = 1'b0;
      send_pkt(8'h68, 1, 9, 0);
      send_pkt(8'h00, 0, 9, 0);
      send_pkt(8'h48, 3, 9, 0);
      send_pkt(8'h7C, 2, 9, 0);
      send_pkt(8'h2C, 8, 4, 32'h0000_0011); settle();
      chk(status === 32'h1480_3C11, "R5 flat textured 0x2C", status, 32'h1480_3C11);

      send_pkt(8'hA0, 2, 1, 32'h0010_0020);
      settle();
      chk(starts == 1, "R9 write launch count", 32'(starts), 32'd1);
      xfer_busy = 1'b1;
      push(32'hE100_0111); push(32'h2400_0000); push(32'h3C00_0000); push(32'hA000_0000);
      xfer_busy = 1'b0;
      settle();
      chk(diverted == 4, "R10 diverted words", 32'(diverted), 32'd4);
      chk(status === 32'h1480_3C11, "R10 status untouched", status, 32'h1480_3C11);
      send_pkt(8'hC0, 2, 2, 32'h0004_0008); settle();
      chk(starts == 2, "R9 read launch count", 32'(starts), 32'd2);

      push(32'h2800_0000); push(32'h1111_1111); push(32'h2222_2222);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      send_pkt(8'hE1, 0, 0, 32'h0000_00AA); settle();
      chk(status === 32'h1480_20AA, "R11 partial packet dropped", status, 32'h1480_20AA);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         miscmp++;
         $display("FAIL R3 watchdog expired actual=%0d expected=done", cyc);
         summary();
         $finish;
      end
   end

endmodule